// File: doc/BRIEF.md
# Masked Set/Clear Output Port

This block is the register side of a 32-pin general-purpose output port. It keeps one output latch per pin. Software never writes the latch directly. It changes the latch by writing ones to a set register or to a clear register, and writing a zero to either register leaves that pin as it was. Two paths reach the latch. The legacy path takes whole-word writes only. The fast path takes any combination of byte lanes and passes each pin through a per-pin access mask.

The block also holds a direction register and an alternate-function select. A pin takes part in set and clear writes only if it is an output that is not handed to a secondary function. The pin outputs and output enables are registered copies of the latch and of the effective direction.

The bus carries a word address, four byte enables, a write strobe and 32 bits of write data. Read data is a combinational decode of the word address, so a read completes in the cycle it is presented. One byte register of the fast set register (pins 8k..8k+7) is a write to the fast set word with only enable k asserted. The half-word registers are the enable patterns 0011 (pins 0–15) and 1100 (pins 16–31).

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch, direction, alternate-select and mask registers all read 0, and `pin_out` and `pin_oe` are 0.
- R2: A write with all four byte enables to the legacy set register (word address 0) sets each latch bit whose data bit is 1 and leaves the other bits unchanged.
- R3: A write to a clear register (legacy word address 1, fast word address 6) clears each latch bit whose data bit is 1 and never raises a latch bit.
- R4: A write to legacy set or legacy clear with any byte enable deasserted has no effect on the latch.
- R5: A set or clear write does not change a pin whose direction bit is 0 (input) or whose alternate-select bit is 1 (secondary function).
- R6: Fast set (word address 5) and fast clear (word address 6) do not change a pin whose mask bit is 1. A mask bit of 0 lets the write through. Legacy writes ignore the mask.
- R7: On the fast path, byte enable k covers data bits and pins 8k..8k+7. Enables 0011 and 1100 reach pins 0–15 and 16–31. Pins in disabled lanes are unchanged.
- R8: Reading either set register returns the latch. Reading either clear register returns 0. Direction (word address 2), alternate-select (3) and mask (4) read back as written. Unused addresses read 0.
- R9: `pin_out` equals the latch one clock later. `pin_oe` equals direction AND NOT alternate-select one clock later.
- R10: Direction, alternate-select and mask writes update only the byte lanes whose enable is set. Direction 1 means output. Alternate-select 1 means secondary function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Word address of the register |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_out | output | 32 | Registered output level per pin |
| pin_oe | output | 32 | Registered output enable per pin |

## Verification
The checker takes for granted that reset is held low for at least one clock edge. It also assumes the bus inputs are stable around each rising edge, since a write is taken at the edge where `bus_we` is high. Its properties only compare latch bits across one edge against the previous cycle's direction, alternate-select and mask, so they place no limits on data values or addresses. The bench drives every input on the falling edge and samples combinational read data and registered pins in the low phase, which keeps every transaction inside those assumptions.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    // word indices of the register map
    localparam int IDX_LSET = 0;
    localparam int IDX_LCLR = 1;
    localparam int IDX_DIR  = 2;
    localparam int IDX_ALT  = 3;
    localparam int IDX_MASK = 4;
    localparam int IDX_FSET = 5;
    localparam int IDX_FCLR = 6;

    typedef struct packed {
        logic leg_set;
        logic leg_clr;
        logic dir;
        logic alt;
        logic mask;
        logic fst_set;
        logic fst_clr;
    } wr_strb_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic              we,
    output wr_strb_t          strb,
    output logic [DATA_W-1:0] lane_m,
    output logic              full_word
);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_m[g*8 +: 8] = {8{be[g]}};
        end
    endgenerate

    assign full_word = &be;

    always_comb begin
        strb = '0;
        if (we) begin
            unique case (addr)
                ADDR_W'(IDX_LSET): strb.leg_set = 1'b1;
                ADDR_W'(IDX_LCLR): strb.leg_clr = 1'b1;
                ADDR_W'(IDX_DIR):  strb.dir     = 1'b1;
                ADDR_W'(IDX_ALT):  strb.alt     = 1'b1;
                ADDR_W'(IDX_MASK): strb.mask    = 1'b1;
                ADDR_W'(IDX_FSET): strb.fst_set = 1'b1;
                ADDR_W'(IDX_FCLR): strb.fst_clr = 1'b1;
                default:           strb         = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_lane_reg.sv
module gpio_lane_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] lane_m,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= (q & ~lane_m) | (wdata & lane_m);
        end
    end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strb_t          strb,
    input  logic              full_word,
    input  logic [DATA_W-1:0] lane_m,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dir_q,
    input  logic [DATA_W-1:0] alt_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] out_q
);

    logic [DATA_W-1:0] base_ok;
    logic [DATA_W-1:0] fast_ok;
    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] clr_v;

    assign base_ok = dir_q & ~alt_q;
    assign fast_ok = base_ok & ~mask_q & lane_m;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (strb.leg_set && full_word) set_v = set_v | (wdata & base_ok);
        if (strb.leg_clr && full_word) clr_v = clr_v | (wdata & base_ok);
        if (strb.fst_set)              set_v = set_v | (wdata & fast_ok);
        if (strb.fst_clr)              clr_v = clr_v | (wdata & fast_ok);
    end

    // clear takes priority over set on a shared bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= (out_q | set_v) & ~clr_v;
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);

    wr_strb_t          strb;
    logic [DATA_W-1:0] lane_m;
    logic              full_word;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] alt_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] out_q;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .be        (bus_be),
        .we        (bus_we),
        .strb      (strb),
        .lane_m    (lane_m),
        .full_word (full_word)
    );

    gpio_lane_reg #(.W(DATA_W)) u_dir (
        .clk (clk), .rst_n (rst_n), .wr (strb.dir),
        .lane_m (lane_m), .wdata (bus_wdata), .q (dir_q)
    );

    gpio_lane_reg #(.W(DATA_W)) u_alt (
        .clk (clk), .rst_n (rst_n), .wr (strb.alt),
        .lane_m (lane_m), .wdata (bus_wdata), .q (alt_q)
    );

    gpio_lane_reg #(.W(DATA_W)) u_mask (
        .clk (clk), .rst_n (rst_n), .wr (strb.mask),
        .lane_m (lane_m), .wdata (bus_wdata), .q (mask_q)
    );

    gpio_out_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (strb),
        .full_word (full_word),
        .lane_m    (lane_m),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .alt_q     (alt_q),
        .mask_q    (mask_q),
        .out_q     (out_q)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(IDX_LSET): bus_rdata = out_q;
            ADDR_W'(IDX_FSET): bus_rdata = out_q;
            ADDR_W'(IDX_DIR):  bus_rdata = dir_q;
            ADDR_W'(IDX_ALT):  bus_rdata = alt_q;
            ADDR_W'(IDX_MASK): bus_rdata = mask_q;
            default:           bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_out <= '0;
            pin_oe  <= '0;
        end else begin
            pin_out <= out_q;
            pin_oe  <= dir_q & ~alt_q;
        end
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LANES-1:0]  bus_be,
    input logic              bus_we,
    input logic [DATA_W-1:0] out_q,
    input logic [DATA_W-1:0] dir_q,
    input logic [DATA_W-1:0] alt_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe
);

    logic past_ok;
    logic is_fast;
    logic is_clr;
    logic is_set;
    logic leg_part;
    logic [DATA_W-1:0] usable;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign is_fast  = bus_we && (bus_addr == ADDR_W'(IDX_FSET) || bus_addr == ADDR_W'(IDX_FCLR));
    assign is_clr   = bus_we && (bus_addr == ADDR_W'(IDX_LCLR) || bus_addr == ADDR_W'(IDX_FCLR));
    assign is_set   = bus_we && (bus_addr == ADDR_W'(IDX_LSET) || bus_addr == ADDR_W'(IDX_FSET));
    assign leg_part = bus_we && !(&bus_be) &&
                      (bus_addr == ADDR_W'(IDX_LSET) || bus_addr == ADDR_W'(IDX_LCLR));
    assign usable   = dir_q & ~alt_q;

    AST_SET_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(is_set) |-> (~out_q & $past(out_q)) == '0); // R2

    AST_CLR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(is_clr) |-> (out_q & ~$past(out_q)) == '0); // R3

    AST_LEGACY_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(leg_part) |-> out_q == $past(out_q)); // R4

    AST_GATED_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((out_q ^ $past(out_q)) & ~$past(usable)) == '0); // R5

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(is_fast) |-> ((out_q ^ $past(out_q)) & $past(mask_q)) == '0); // R6

    AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> pin_out == $past(out_q) && pin_oe == $past(usable)); // R9

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(bus_we) |-> $stable(out_q)); // R2

endmodule

bind gpio_port gpio_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .bus_we   (bus_we),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .alt_q    (alt_q),
    .mask_q   (mask_q),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

    localparam int AW = 4;
    localparam logic [AW-1:0] A_LSET = 4'd0, A_LCLR = 4'd1, A_DIR = 4'd2,
                              A_ALT = 4'd3, A_MASK = 4'd4, A_FSET = 4'd5,
                              A_FCLR = 4'd6, A_NONE = 4'd9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata, pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port #(.ADDR_W(AW)) uut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_be (bus_be),
        .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_out (pin_out), .pin_oe (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic pins_chk(input string req, input logic [31:0] e_out, input logic [31:0] e_oe);
        @(negedge clk);
        check({req, " pin_out"}, pin_out, e_out);
        check({req, " pin_oe"}, pin_oe, e_oe);
    endtask

    task automatic t_reset;
        rd_chk("R1 latch", A_LSET, 32'h0);
        rd_chk("R1 dir", A_DIR, 32'h0);
        rd_chk("R1 alt", A_ALT, 32'h0);
        rd_chk("R1 mask", A_MASK, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
    endtask

    task automatic t_config;
        wr(A_DIR, 4'hF, 32'h0000_FFFF);
        wr(A_ALT, 4'hF, 32'h0000_00F0);
        wr(A_DIR, 4'hC, 32'hFF12_3456);     // R10 upper lanes only
        rd_chk("R10 dir lanes", A_DIR, 32'hFF12_FFFF);
        wr(A_DIR, 4'h4, 32'h0000_0000);     // R10 clear lane 2
        rd_chk("R10 dir lane2", A_DIR, 32'hFF00_FFFF);
        rd_chk("R8 alt readback", A_ALT, 32'h0000_00F0);
        rd_chk("R8 unused addr", A_NONE, 32'h0);
    endtask

    task automatic t_legacy;
        wr(A_LSET, 4'hF, 32'hFFFF_FFFF);    // usable pins 0xFF00FF0F
        rd_chk("R2/R5 legacy set", A_LSET, 32'hFF00_FF0F);
        rd_chk("R8 fast set reads latch", A_FSET, 32'hFF00_FF0F);
        rd_chk("R8 clear reads 0", A_LCLR, 32'h0);
        wr(A_LCLR, 4'hF, 32'h0000_000F);
        rd_chk("R3 legacy clear", A_LSET, 32'hFF00_FF00);
        wr(A_LSET, 4'hF, 32'h0000_0000);
        rd_chk("R2 zero data", A_LSET, 32'hFF00_FF00);
        wr(A_LSET, 4'h3, 32'h0000_000F);
        rd_chk("R4 partial set", A_LSET, 32'hFF00_FF00);
        wr(A_LCLR, 4'h7, 32'hFFFF_FFFF);
        rd_chk("R4 partial clear", A_LSET, 32'hFF00_FF00);
        pins_chk("R9", 32'hFF00_FF00, 32'hFF00_FF0F);
    endtask

    task automatic t_mask;
        wr(A_MASK, 4'hF, 32'h0000_FF00);
        rd_chk("R8 mask readback", A_MASK, 32'h0000_FF00);
        wr(A_FCLR, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R6 masked clear", A_LSET, 32'h0000_FF00);
        wr(A_LSET, 4'hF, 32'h0000_0F00);
        rd_chk("R6 legacy ignores mask", A_LSET, 32'h0000_FF00);
        wr(A_FSET, 4'hF, 32'h0000_00FF);
        rd_chk("R6/R5 fast set", A_LSET, 32'h0000_FF0F);
        wr(A_MASK, 4'hF, 32'h0);
    endtask

    task automatic t_lanes;
        wr(A_FCLR, 4'h1, 32'hFFFF_FFFF);
        rd_chk("R7 byte0 clear", A_LSET, 32'h0000_FF00);
        wr(A_FSET, 4'h8, 32'hFFFF_FFFF);
        rd_chk("R7 byte3 set", A_LSET, 32'hFF00_FF00);
        wr(A_FSET, 4'h1, 32'hFFFF_FFFF);
        rd_chk("R7 byte0 set", A_LSET, 32'hFF00_FF0F);
        wr(A_FSET, 4'h4, 32'hFFFF_FFFF);
        rd_chk("R5 input lane", A_LSET, 32'hFF00_FF0F);
        wr(A_FCLR, 4'hC, 32'hFFFF_FFFF);
        rd_chk("R7 upper half clear", A_LSET, 32'h0000_FF0F);
        wr(A_FCLR, 4'h3, 32'hFFFF_0F00);
        rd_chk("R7 lower half clear", A_LSET, 32'h0000_F00F);
        wr(A_FSET, 4'h2, 32'hFFFF_FFFF);
        rd_chk("R7 byte1 set", A_LSET, 32'h0000_FF0F);
        wr(A_ALT, 4'hF, 32'h0000_000F);
        wr(A_LCLR, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R5 alt pins kept", A_LSET, 32'h0000_000F);
        pins_chk("R9 after alt", 32'h0000_000F, 32'hFF00_FFF0);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_config();
        t_legacy();
        t_mask();
        t_lanes();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule